// File: doc/BRIEF.md
# Interrupt Acceptance and Vector Generator

This block sits on the processor side of an interrupt path. An external arbiter presents the winning pending priority number with a valid flag. The block compares that number against the processor's current priority level. It takes the interrupt only when the pending number is strictly higher and the global interrupt enable is set. When it takes an interrupt, it raises a one-cycle take pulse toward the fetch logic and a one-cycle acknowledge toward the arbiter. In the same cycle it presents the entry address of the handler for that priority.

The entry address is formed by a bitwise OR, not an addition. The block shifts the priority number and ORs it into a software-written vector base register. Bit 0 of the base register selects the entry spacing: 0 shifts the priority left by 5 to give 32-byte entries, and 1 shifts it left by 3 to give 8-byte entries. A table covering all 256 priorities at 32-byte spacing therefore needs an 8 KB aligned base. Base bits that overlap the shifted priority field and are written to one mask the priority. Setting all of them funnels every priority onto a single shared entry, which suits a dispatcher implemented in software.

Acceptance saves the previous priority level and enable. It then loads the current level with the accepted priority and clears the enable. A return strobe restores both from the saved copy.

Top module: `intr_entry_unit`

## Requirements
- R1: After synchronous reset, the take pulse, the acknowledge, the vector address, the current priority, the enable and the base register are all zero.
- R2: An interrupt is accepted only when the pending valid flag is high and the pending priority is strictly greater than the current priority; an equal or lower priority is never taken.
- R3: While the enable is clear, nothing is accepted. An acceptance clears the enable, and a one-cycle enable-set strobe sets it again.
- R4: On acceptance, the current priority becomes the accepted pending priority at the same clock edge that raises the take pulse.
- R5: The take and the acknowledge are high together for exactly one cycle, namely the cycle after the edge at which acceptance was decided.
- R6: With base bit 0 at 0, the vector address equals base OR (priority << 5).
- R7: With base bit 0 at 1, the vector address equals base OR (priority << 3), with bit 0 cleared.
- R8: The combination is a bitwise OR. For example, a base of 0x800F1FE0 yields 0x800F1FE0 for every priority, because bits 12..5 are all ones.
- R9: Bit 0 of the vector address is always 0.
- R10: A return strobe restores the current priority and the enable to the values they had just before the latest acceptance. When return and acceptance coincide, the return wins and nothing is taken.
- R11: A base write takes effect at its clock edge. An acceptance decided at that same edge uses the previous base.
- R12: With the pending valid flag low, no interrupt is taken, whatever the pending priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_prio | input | 8 | Pending priority number from the arbiter |
| pend_valid | input | 1 | Pending priority is valid |
| ien_set | input | 1 | One-cycle strobe that sets the global enable |
| rfe | input | 1 | Return strobe; restores the saved priority and enable |
| base_we | input | 1 | Write strobe for the vector base register |
| base_wdata | input | 32 | Data written to the vector base register |
| take | output | 1 | One-cycle interrupt take pulse |
| ack | output | 1 | One-cycle acknowledge to the arbiter |
| vec_addr | output | 32 | Entry address of the accepted interrupt |
| ccpn_o | output | 8 | Current processor priority level |
| ien_o | output | 1 | Global interrupt enable state |

## Verification
The decision, the take and acknowledge pulses, the vector address and the new priority all appear one clock after the edge that samples a qualifying pending request. A return, an enable-set or a base write is visible one clock after its strobe. The bench drives every input on the falling edge. A behavioural model is stepped on each rising edge using the values that were just driven, and all outputs are compared with the model at the following falling edge. Directed checks sample exactly one falling edge after the rising edge that should produce each result; the computed addresses are written out as constants.

// File: rtl/intr_pkg.sv
package intr_pkg;
    localparam int PRIO_W = 8;
    localparam int ADDR_W = 32;
    localparam int SHIFT_WIDE = 5;
    localparam int SHIFT_NARROW = 3;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        prio_t level;
        logic  en;
    } prio_ctx_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_ACCEPT = 2'd1,
        EV_RETURN = 2'd2,
        EV_ENABLE = 2'd3
    } prio_event_e;

    function automatic addr_t entry_addr(addr_t base, prio_t prio);
        addr_t wide;
        wide = addr_t'(prio);
        if (base[0])
            entry_addr = (base | (wide << SHIFT_NARROW)) & ~addr_t'(1);
        else
            entry_addr = (base | (wide << SHIFT_WIDE)) & ~addr_t'(1);
    endfunction
endpackage

// File: rtl/intr_decide.sv
module intr_decide
    import intr_pkg::*;
(
    input  prio_t       pend_prio,
    input  logic        pend_valid,
    input  prio_ctx_t   cur,
    input  logic        rfe,
    input  logic        ien_set,
    output prio_event_e ev
);
    logic wins;

    always_comb begin
        wins = pend_valid && cur.en && (pend_prio > cur.level);
        if (rfe)
            ev = EV_RETURN;
        else if (wins)
            ev = EV_ACCEPT;
        else if (ien_set)
            ev = EV_ENABLE;
        else
            ev = EV_NONE;
    end
endmodule

// File: rtl/intr_prio_state.sv
module intr_prio_state
    import intr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  prio_event_e ev,
    input  prio_t       pend_prio,
    output prio_ctx_t   cur
);
    prio_ctx_t saved;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            saved <= '0;
        end else begin
            unique case (ev)
                EV_ACCEPT: begin
                    saved     <= cur;
                    cur.level <= pend_prio;
                    cur.en    <= 1'b0;
                end
                EV_RETURN: cur <= saved;
                EV_ENABLE: cur.en <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/intr_vecgen.sv
module intr_vecgen
    import intr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  base_we,
    input  addr_t base_wdata,
    input  prio_t prio,
    output addr_t addr
);
    addr_t base_q;

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (base_we)
            base_q <= base_wdata;
    end

    assign addr = entry_addr(base_q, prio);
endmodule

// File: rtl/intr_entry_unit.sv
module intr_entry_unit
    import intr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_valid,
    input  logic              ien_set,
    input  logic              rfe,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              take,
    output logic              ack,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [PRIO_W-1:0] ccpn_o,
    output logic              ien_o
);
    prio_event_e ev;
    prio_ctx_t   cur;
    addr_t       next_addr;

    intr_decide u_decide (
        .pend_prio (pend_prio),
        .pend_valid(pend_valid),
        .cur       (cur),
        .rfe       (rfe),
        .ien_set   (ien_set),
        .ev        (ev)
    );

    intr_prio_state u_state (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .pend_prio(pend_prio),
        .cur      (cur)
    );

    intr_vecgen u_vec (
        .clk       (clk),
        .rst       (rst),
        .base_we   (base_we),
        .base_wdata(base_wdata),
        .prio      (pend_prio),
        .addr      (next_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take     <= 1'b0;
            ack      <= 1'b0;
            vec_addr <= '0;
        end else begin
            take <= (ev == EV_ACCEPT);
            ack  <= (ev == EV_ACCEPT);
            if (ev == EV_ACCEPT)
                vec_addr <= next_addr;
        end
    end

    assign ccpn_o = cur.level;
    assign ien_o  = cur.en;
endmodule

// File: rtl/intr_entry_unit_chk.sv
module intr_entry_unit_chk
    import intr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input prio_t       pend_prio,
    input logic        pend_valid,
    input logic        rfe,
    input logic        take,
    input logic        ack,
    input addr_t       vec_addr,
    input prio_t       ccpn_o,
    input logic        ien_o
);
    p_take_ack_pair_r5: assert property (@(posedge clk) disable iff (rst)
        take == ack);

    p_take_single_r5: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    p_take_clears_en_r3: assert property (@(posedge clk) disable iff (rst)
        take |-> !ien_o);

    p_strict_greater_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(take) |-> $past(pend_valid) && ($past(pend_prio) > $past(ccpn_o)));

    p_level_loaded_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(take) |-> ccpn_o == $past(pend_prio));

    p_addr_even_r9: assert property (@(posedge clk) disable iff (rst)
        vec_addr[0] == 1'b0);

    p_return_wins_r10: assert property (@(posedge clk) disable iff (rst)
        rfe |=> !take);
endmodule

bind intr_entry_unit intr_entry_unit_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .pend_prio (pend_prio),
    .pend_valid(pend_valid),
    .rfe       (rfe),
    .take      (take),
    .ack       (ack),
    .vec_addr  (vec_addr),
    .ccpn_o    (ccpn_o),
    .ien_o     (ien_o)
);

// File: tb/test_intr_entry_unit.sv
module test_intr_entry_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pend_prio = '0;
    logic        pend_valid = 1'b0;
    logic        ien_set = 1'b0;
    logic        rfe = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        take, ack, ien_o;
    logic [31:0] vec_addr;
    logic [7:0]  ccpn_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;
    string phase = "R1";

    // reference model state
    logic [31:0] m_base;
    logic [7:0]  m_lvl, m_sv_lvl;
    logic        m_en, m_sv_en, m_take;
    logic [31:0] m_addr;

    always #5 clk = ~clk;

    intr_entry_unit i_intr_entry_unit (
        .clk(clk), .rst(rst), .pend_prio(pend_prio), .pend_valid(pend_valid),
        .ien_set(ien_set), .rfe(rfe), .base_we(base_we), .base_wdata(base_wdata),
        .take(take), .ack(ack), .vec_addr(vec_addr), .ccpn_o(ccpn_o), .ien_o(ien_o)
    );

    function automatic logic [31:0] ref_addr(logic [31:0] b, logic [7:0] p);
        logic [31:0] shifted;
        shifted = b[0] ? (32'(p) << 3) : (32'(p) << 5);
        return (b | shifted) & 32'hFFFF_FFFE;
    endfunction

    always @(posedge clk) begin
        logic [31:0] old_base;
        if (rst) begin
            m_base = '0; m_lvl = '0; m_sv_lvl = '0; m_en = 0; m_sv_en = 0;
            m_take = 0; m_addr = '0;
        end else begin
            old_base = m_base;
            if (base_we) m_base = base_wdata;
            m_take = 0;
            if (rfe) begin
                m_lvl = m_sv_lvl; m_en = m_sv_en;
            end else if (pend_valid && m_en && pend_prio > m_lvl) begin
                m_sv_lvl = m_lvl; m_sv_en = m_en;
                m_addr = ref_addr(old_base, pend_prio);
                m_lvl = pend_prio; m_en = 0; m_take = 1;
            end else if (ien_set) begin
                m_en = 1;
            end
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(phase, "take", 32'(take), 32'(m_take));
            chk(phase, "ack", 32'(ack), 32'(m_take));
            chk(phase, "vec_addr", vec_addr, m_addr);
            chk(phase, "ccpn", 32'(ccpn_o), 32'(m_lvl));
            chk(phase, "ien", 32'(ien_o), 32'(m_en));
        end
    end

    task automatic nedge(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe_en();
        ien_set = 1; nedge(1); ien_set = 0;
    endtask

    task automatic strobe_rfe();
        rfe = 1; nedge(1); rfe = 0;
    endtask

    task automatic wr_base(logic [31:0] v);
        base_we = 1; base_wdata = v; nedge(1); base_we = 0;
    endtask

    // present a request; result is due at the next falling edge
    task automatic request(logic [7:0] p);
        pend_valid = 1; pend_prio = p; nedge(1);
    endtask

    initial begin
        nedge(3);
        rst = 0;
        nedge(1);
        chk("R1", "take", 32'(take), 0);
        chk("R1", "vec_addr", vec_addr, 0);
        chk("R1", "ccpn", 32'(ccpn_o), 0);
        chk("R1", "ien", 32'(ien_o), 0);

        phase = "R3";
        wr_base(32'h8000_6000);
        request(8'd4);
        chk("R3", "no take while disabled", 32'(take), 0);
        pend_valid = 0;
        strobe_en();
        phase = "R6";
        request(8'd4);
        chk("R6", "vec 32-byte", vec_addr, 32'h8000_6080);
        chk("R4", "ccpn loaded", 32'(ccpn_o), 4);
        chk("R5", "take high", 32'(take), 1);
        chk("R3", "enable cleared", 32'(ien_o), 0);
        nedge(1);
        chk("R5", "take single", 32'(take), 0);
        pend_valid = 0;

        phase = "R2";
        strobe_en();
        request(8'd4);
        chk("R2", "equal not taken", 32'(take), 0);
        request(8'd3);
        chk("R2", "lower not taken", 32'(take), 0);
        phase = "R12";
        pend_valid = 0; pend_prio = 8'hFF; nedge(2);
        chk("R12", "invalid not taken", 32'(take), 0);

        phase = "R10";
        request(8'd5);
        chk("R6", "vec prio5", vec_addr, 32'h8000_60A0);
        pend_valid = 0;
        strobe_rfe();
        chk("R10", "ccpn restored", 32'(ccpn_o), 4);
        chk("R10", "enable restored", 32'(ien_o), 1);

        phase = "R7";
        wr_base(32'h8000_6001);
        request(8'd9);
        chk("R7", "vec 8-byte", vec_addr, 32'h8000_6048);
        chk("R9", "bit0 clear", 32'(vec_addr[0]), 0);
        pend_valid = 0;
        strobe_rfe();

        phase = "R8";
        wr_base(32'h800F_1FE0);
        request(8'h37);
        chk("R8", "masked prio 0x37", vec_addr, 32'h800F_1FE0);
        pend_valid = 0;
        strobe_rfe();
        request(8'hC8);
        chk("R8", "masked prio 0xC8", vec_addr, 32'h800F_1FE0);
        pend_valid = 0;
        strobe_rfe();

        phase = "R11";
        base_we = 1; base_wdata = 32'h8000_2000;
        request(8'd6);
        base_we = 0;
        chk("R11", "old base used", vec_addr, 32'h800F_1FE0);
        pend_valid = 0;
        strobe_rfe();
        request(8'd6);
        chk("R11", "new base used", vec_addr, 32'h8000_20C0);
        pend_valid = 0;

        phase = "R10";
        strobe_en();
        rfe = 1; pend_valid = 1; pend_prio = 8'd20; nedge(1);
        rfe = 0; pend_valid = 0;
        chk("R10", "return beats accept", 32'(take), 0);
        nedge(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_fails++;
            done = 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule